// File: doc/BRIEF.md
# Power-Good Sequencer with Fault Latch

This block drives the open-drain power-good line of one converter phase. It watches a digital feedback code against a reference code. Power-good is released only when three things hold: the feedback has crossed a selectable fraction of the reference, the soft-start ramp reports done, and a programmable delay has run out. From power-up until then, the output holds the line low. Any protection fault pulls the line low again and keeps it there. Only the start of a new soft start clears that latched low.

In a multi-phase system the same line is shared by all phases. With bidirectional mode selected, the block samples the line through a two-flop synchronizer. A low that this phase is not causing is treated as a fault reported by another phase. Such a low must persist for four 1 µs ticks before it counts. In output-only mode the sampled line is ignored. The output is an active-high pull-down enable. The line reads high only when the pull-down is released. The comparators and the external pull-up lie outside this block.

Top module: `pgood_seq`

## Requirements
- R1: After reset, `pd_en` is 1 (line held low) and `peer_fault` is 0.
- R2: The feedback counts as qualified when `fb_code*40 >= ref_code*(36+thr_sel)`. The four `thr_sel` values 0, 1, 2 and 3 therefore select 90%, 92.5%, 95% and 97.5% of the reference.
- R3: `pd_en` can fall only after a cycle in which both the feedback is qualified and `ss_done` is 1. With `dly_sel`=0, `pd_en` is 0 in the cycle after the first such cycle.
- R4: With `dly_sel`=N>0, release happens on the N*TICKS_PER_MS-th tick counted while qualified. A tick is asserted once every CLKS_PER_TICK clocks, free-running from reset, first in clock CLKS_PER_TICK-1.
- R5: If qualification is lost during the delay, the sequencer returns to waiting and the delay restarts from zero.
- R6: Any of `flt_uv`, `flt_ov`, `flt_ot`, `flt_vin_uv` or an asserted `peer_fault` makes `pd_en` 1 in the next cycle, from any state.
- R7: After a fault, `pd_en` stays 1 until `ss_start` is pulsed while no fault is present. A fault present in the same cycle as `ss_start` wins. After the pulse, sequencing restarts as from reset.
- R8: When `bidir_mode`=1, `peer_fault` rises when the synchronized line has been low across 4 ticks. Every cycle of that window must also see `pd_en` inactive in the current and the two previous cycles. Any cycle that breaks the condition clears the count.
- R9: A line low spanning fewer than 4 ticks never raises `peer_fault` and does not pull power-good down.
- R10: When `bidir_mode`=0, the line input has no effect and `peer_fault` stays 0.
- R11: Once released, power-good stays released when the feedback drops. Only faults pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | CODE_W | Feedback voltage code |
| ref_code | input | CODE_W | Reference voltage code |
| thr_sel | input | 2 | Rising threshold select |
| dly_sel | input | 4 | Release delay in milliseconds (0 = none) |
| ss_start | input | 1 | Pulse marking the start of a new soft start |
| ss_done | input | 1 | Soft-start ramp finished |
| flt_uv | input | 1 | Output under-voltage fault |
| flt_ov | input | 1 | Output over-voltage fault |
| flt_ot | input | 1 | Over-temperature fault |
| flt_vin_uv | input | 1 | Input under-voltage fault |
| bidir_mode | input | 1 | 1 = line is also a fault input from other phases |
| pin_in | input | 1 | Sampled level of the power-good line |
| pd_en | output | 1 | Pull-down enable (1 = line driven low) |
| peer_fault | output | 1 | Another phase is holding the line low |

## Verification
The bench attacks both ends of each threshold code. A feedback one code below the fraction must keep the line low, and the exact fraction must release it. A wrong numerator shows up as a release at the wrong code. It drops qualification in the middle of a delay, so that a counter that only pauses, instead of restarting, releases too early. It keeps the fault latch in play. A fault is removed without a soft start, and a soft start is given while the fault is still present. A latch that leaks would release in either case. On the shared line it sends lows just shorter than the filter window, which a filter that does not clear would turn into a spurious trip. It sends lows long enough to trip in bidirectional mode, and the same lows in output-only mode. It also relies on the line being low from this phase's own drive before release. A filter that fails to mask its own pull-down would trip the moment power-good rises.

// File: rtl/pgood_pkg.sv
package pgood_pkg;
  typedef enum logic [1:0] {
    PG_WAIT  = 2'd0,
    PG_DELAY = 2'd1,
    PG_GOOD  = 2'd2,
    PG_LATCH = 2'd3
  } pg_state_e;

  localparam int unsigned THR_DEN  = 40;
  localparam int unsigned THR_BASE = 36;
  localparam int unsigned DLY_MAX  = 15;

  // numerator of the rising threshold fraction over THR_DEN
  function automatic logic [5:0] thr_num(input logic [1:0] sel);
    return 6'(THR_BASE) + {4'b0000, sel};
  endfunction
endpackage

// File: rtl/pg_tick_gen.sv
module pg_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLKS_PER_TICK <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CLKS_PER_TICK);
      logic [DW-1:0] div_q;
      assign tick = (div_q == DW'(CLKS_PER_TICK - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
      // R4: ticks are isolated single-cycle strobes
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pg_thresh_cmp.sv
module pg_thresh_cmp
  import pgood_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [1:0]        thr_sel,
  output logic              above
);
  localparam int unsigned PW = CODE_W + 6;
  logic [PW-1:0] fb_scaled;
  logic [PW-1:0] ref_scaled;

  always_comb begin
    fb_scaled  = PW'(fb_code) * PW'(THR_DEN);
    ref_scaled = PW'(ref_code) * PW'(thr_num(thr_sel));
    above      = (fb_scaled >= ref_scaled);
  end
endmodule

// File: rtl/pg_peer_filter.sv
module pg_peer_filter #(
  parameter int unsigned GLITCH_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bidir_mode,
  input  logic pin_in,
  input  logic pd_en,
  output logic peer_fault
);
  localparam int unsigned FC_W = $clog2(GLITCH_TICKS + 1);

  logic          sync1_q, sync2_q;
  logic          pd_d1_q, pd_d2_q;
  logic          own_drive;
  logic          foreign_low;
  logic [FC_W-1:0] low_cnt_q;

  // two-flop synchronizer; line idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      pd_d1_q <= 1'b1;
      pd_d2_q <= 1'b1;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      pd_d1_q <= pd_en;
      pd_d2_q <= pd_d1_q;
    end
  end

  // mask the synchronizer latency after this phase releases its own pull-down
  assign own_drive   = pd_en | pd_d1_q | pd_d2_q;
  assign foreign_low = bidir_mode & ~sync2_q & ~own_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt_q <= '0;
    else if (!foreign_low)
      low_cnt_q <= '0;
    else if (tick && (low_cnt_q != FC_W'(GLITCH_TICKS)))
      low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign peer_fault = (low_cnt_q == FC_W'(GLITCH_TICKS));

  // R10: output-only mode never reports a peer fault
  p_mode_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_mode |=> !peer_fault);
  // R9: the report can only appear on a tick boundary
  p_rise_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peer_fault) |-> $past(tick));
  // R8: a report needs the line low while this phase was not driving it
  p_rise_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peer_fault) |-> $past(bidir_mode && !sync2_q && !pd_en));
endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
  import pgood_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       qual,
  input  logic       fault_any,
  input  logic       ss_start,
  input  logic [3:0] dly_sel,
  output logic       pd_en
);
  localparam int unsigned MAX_TICKS = DLY_MAX * TICKS_PER_MS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int unsigned CW1       = CNT_W + 1;

  pg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CW1-1:0]   target;
  logic [CW1-1:0]   cnt_next;

  assign target   = CW1'(dly_sel) * CW1'(TICKS_PER_MS);
  assign cnt_next = CW1'(cnt_q) + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (fault_any) begin
      state_d = PG_LATCH;
    end else if (ss_start) begin
      state_d = PG_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PG_WAIT: begin
          if (qual) begin
            cnt_d   = '0;
            state_d = (dly_sel == 4'd0) ? PG_GOOD : PG_DELAY;
          end
        end
        PG_DELAY: begin
          if (!qual) begin
            state_d = PG_WAIT;
            cnt_d   = '0;
          end else if (tick) begin
            if (cnt_next >= target) state_d = PG_GOOD;
            else                    cnt_d   = cnt_next[CNT_W-1:0];
          end
        end
        PG_GOOD:  state_d = PG_GOOD;
        PG_LATCH: state_d = PG_LATCH;
        default:  state_d = PG_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pd_en = (state_q != PG_GOOD);

  // R6: any fault pulls the line low on the next edge
  p_fault_forces_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> pd_en);
  // R7: the latch only opens on a soft-start pulse
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_LATCH && !ss_start) |=> (state_q == PG_LATCH));
  // R3: release only follows a qualified cycle
  p_release_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_en) |-> $past(qual));
  // R4: the delay can only end on a tick
  p_delay_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_DELAY && !tick) |=> pd_en);
  // R11: the released state is left only through a fault or a soft start
  p_good_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_GOOD && !fault_any && !ss_start) |=> !pd_en);
endmodule

// File: rtl/pgood_seq.sv
module pgood_seq #(
  parameter int unsigned CODE_W        = 12,
  parameter int unsigned CLKS_PER_TICK = 100,
  parameter int unsigned TICKS_PER_MS  = 1000,
  parameter int unsigned GLITCH_TICKS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [1:0]        thr_sel,
  input  logic [3:0]        dly_sel,
  input  logic              ss_start,
  input  logic              ss_done,
  input  logic              flt_uv,
  input  logic              flt_ov,
  input  logic              flt_ot,
  input  logic              flt_vin_uv,
  input  logic              bidir_mode,
  input  logic              pin_in,
  output logic              pd_en,
  output logic              peer_fault
);
  logic tick;
  logic above;
  logic qual;
  logic fault_any;

  pg_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  pg_thresh_cmp #(.CODE_W(CODE_W)) u_cmp (
    .fb_code (fb_code),
    .ref_code(ref_code),
    .thr_sel (thr_sel),
    .above   (above)
  );

  pg_peer_filter #(.GLITCH_TICKS(GLITCH_TICKS)) u_peer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bidir_mode(bidir_mode),
    .pin_in    (pin_in),
    .pd_en     (pd_en),
    .peer_fault(peer_fault)
  );

  assign qual      = above & ss_done;
  assign fault_any = flt_uv | flt_ov | flt_ot | flt_vin_uv | peer_fault;

  pg_seq_fsm #(.TICKS_PER_MS(TICKS_PER_MS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .qual     (qual),
    .fault_any(fault_any),
    .ss_start (ss_start),
    .dly_sel  (dly_sel),
    .pd_en    (pd_en)
  );

  // R1: reset leaves the line held low with no peer report
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (pd_en && !peer_fault));
endmodule

// File: tb/pgood_seq_tb_top.sv
`timescale 1ns/1ps
module pgood_seq_tb_top;
  localparam int CODE_W = 10;
  localparam int CPT    = 4;
  localparam int TPM    = 5;
  localparam int GT     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CODE_W-1:0] fb_code = '0;
  logic [CODE_W-1:0] ref_code = 10'd1000;
  logic [1:0]        thr_sel = 2'd0;
  logic [3:0]        dly_sel = 4'd0;
  logic ss_start = 0, ss_done = 0;
  logic flt_uv = 0, flt_ov = 0, flt_ot = 0, flt_vin_uv = 0;
  logic bidir_mode = 0;
  logic ext_pull = 0;
  logic pin_in;
  logic pd_en, peer_fault;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  // wired open-drain line: this phase or another phase may pull it low
  assign pin_in = !(pd_en | ext_pull);

  pgood_seq #(.CODE_W(CODE_W), .CLKS_PER_TICK(CPT), .TICKS_PER_MS(TPM),
              .GLITCH_TICKS(GT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ref_code(ref_code),
    .thr_sel(thr_sel), .dly_sel(dly_sel), .ss_start(ss_start), .ss_done(ss_done),
    .flt_uv(flt_uv), .flt_ov(flt_ov), .flt_ot(flt_ot), .flt_vin_uv(flt_vin_uv),
    .bidir_mode(bidir_mode), .pin_in(pin_in), .pd_en(pd_en), .peer_fault(peer_fault)
  );

  // ---------------- behavioural reference model ----------------
  // m_mode: 0 waiting, 1 delaying, 2 released, 3 latched
  int m_mode, m_dcnt, m_div, m_lowcnt;
  bit m_s1, m_s2, m_h1, m_h2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_dcnt = 0; m_div = 0; m_lowcnt = 0;
      m_s1 = 1; m_s2 = 1; m_h1 = 1; m_h2 = 1;
    end else begin
      bit tk, ext, q, flt, pdv, own;
      int need;
      tk   = (m_div == CPT - 1);
      ext  = (m_lowcnt == GT);
      q    = (int'(fb_code) * 40 >= int'(ref_code) * (36 + int'(thr_sel))) && ss_done;
      flt  = flt_uv || flt_ov || flt_ot || flt_vin_uv || ext;
      pdv  = (m_mode != 2);
      own  = pdv || m_h1 || m_h2;
      need = int'(dly_sel) * TPM;
      if (bidir_mode && !m_s2 && !own) begin
        if (tk && m_lowcnt < GT) m_lowcnt++;
      end else m_lowcnt = 0;
      if (flt) m_mode = 3;
      else if (ss_start) begin m_mode = 0; m_dcnt = 0; end
      else if (m_mode == 0) begin
        if (q) begin m_dcnt = 0; m_mode = (dly_sel == 0) ? 2 : 1; end
      end else if (m_mode == 1) begin
        if (!q) begin m_mode = 0; m_dcnt = 0; end
        else if (tk) begin
          if (m_dcnt + 1 >= need) m_mode = 2;
          else m_dcnt++;
        end
      end
      m_s2 = m_s1; m_s1 = pin_in;
      m_h2 = m_h1; m_h1 = pdv;
      m_div = tk ? 0 : m_div + 1;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pd_en !== (m_mode != 2)) begin
        errors++;
        $display("FAIL %s pd_en act=%0d exp=%0d t=%0t", cur_req, pd_en, (m_mode != 2), $time);
      end
      checks++;
      if (peer_fault !== (m_lowcnt == GT)) begin
        errors++;
        $display("FAIL %s peer_fault act=%0d exp=%0d t=%0t", cur_req, peer_fault, (m_lowcnt == GT), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_pd(input logic e, input string tag);
    checks++;
    if (pd_en !== e) begin
      errors++;
      $display("FAIL %s direct pd_en act=%0d exp=%0d t=%0t", tag, pd_en, e, $time);
    end
  endtask

  task automatic expect_peer(input logic e, input string tag);
    checks++;
    if (peer_fault !== e) begin
      errors++;
      $display("FAIL %s direct peer_fault act=%0d exp=%0d t=%0t", tag, peer_fault, e, $time);
    end
  endtask

  // latch via a fault, then open with a clean soft-start pulse
  task automatic restart();
    flt_uv = 1; cyc(1);
    flt_uv = 0; ss_start = 1; cyc(1);
    ss_start = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    cur_req = "R1";
    expect_pd(1'b1, "R1");
    expect_peer(1'b0, "R1");

    // R3: qualified feedback without soft-start done holds low
    cur_req = "R3";
    fb_code = 10'd1000; ss_done = 0; cyc(10);
    expect_pd(1'b1, "R3");
    ss_done = 1; cyc(2);
    expect_pd(1'b0, "R3");

    // R2: each threshold code, one below and exactly at the fraction
    cur_req = "R2";
    for (int k = 0; k < 4; k++) begin
      int th;
      th = 1000 * (36 + k) / 40;
      thr_sel = 2'(k);
      fb_code = 10'(th - 1);
      restart(); cyc(6);
      expect_pd(1'b1, "R2");
      fb_code = 10'(th); cyc(2);
      expect_pd(1'b0, "R2");
    end
    thr_sel = 0; fb_code = 10'd1000;

    // R4: delay of 3 ms = 15 ticks = 60 clocks
    cur_req = "R4";
    dly_sel = 4'd3;
    restart(); cyc(50);
    expect_pd(1'b1, "R4");
    cyc(20);
    expect_pd(1'b0, "R4");

    // R5: losing qualification mid-delay restarts the count
    cur_req = "R5";
    restart(); cyc(40);
    fb_code = 10'd0; cyc(1);
    fb_code = 10'd1000; cyc(40);
    expect_pd(1'b1, "R5");
    cyc(30);
    expect_pd(1'b0, "R5");
    dly_sel = 4'd0;

    // R11: released output ignores falling feedback
    cur_req = "R11";
    fb_code = 10'd0; cyc(20);
    expect_pd(1'b0, "R11");
    fb_code = 10'd1000;

    // R6: each protection fault from released
    cur_req = "R6";
    for (int f = 0; f < 4; f++) begin
      restart(); cyc(3);
      expect_pd(1'b0, "R6");
      case (f)
        0: flt_uv = 1;
        1: flt_ov = 1;
        2: flt_ot = 1;
        default: flt_vin_uv = 1;
      endcase
      cyc(1);
      flt_uv = 0; flt_ov = 0; flt_ot = 0; flt_vin_uv = 0;
      expect_pd(1'b1, "R6");
    end

    // R7: latch survives fault removal and a soft start given under a fault
    cur_req = "R7";
    cyc(40);
    expect_pd(1'b1, "R7");
    flt_ot = 1; ss_start = 1; cyc(1);
    ss_start = 0; cyc(1); flt_ot = 0; cyc(20);
    expect_pd(1'b1, "R7");
    ss_start = 1; cyc(1); ss_start = 0; cyc(3);
    expect_pd(1'b0, "R7");

    // R9: short foreign lows are rejected in bidirectional mode
    cur_req = "R9";
    bidir_mode = 1; cyc(10);
    ext_pull = 1; cyc(8);
    ext_pull = 0; cyc(20);
    expect_pd(1'b0, "R9");
    expect_peer(1'b0, "R9");

    // R10: long foreign low ignored in output-only mode
    cur_req = "R10";
    bidir_mode = 0;
    ext_pull = 1; cyc(40);
    expect_pd(1'b0, "R10");
    expect_peer(1'b0, "R10");
    ext_pull = 0; cyc(5);

    // R8: long foreign low trips in bidirectional mode; own drive before release is masked
    cur_req = "R8";
    bidir_mode = 1;
    restart(); cyc(30);
    expect_pd(1'b0, "R8");
    expect_peer(1'b0, "R8");
    ext_pull = 1; cyc(30);
    expect_pd(1'b1, "R8");
    ext_pull = 0; cyc(10);
    expect_pd(1'b1, "R8");
    ss_start = 1; cyc(1); ss_start = 0; cyc(10);
    expect_pd(1'b0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule